// File: doc/BRIEF.md
# Convert-Start Gating and Power-Mode Sequencer

This block is the digital control core of a sampling converter. It watches one asynchronous convert-start input. A rising edge on that input wakes the converter from sleep and launches a self-timed power-up interval. The sample is held and a conversion begins when both the power-up interval and the external input have ended. That is the later of the two falling edges of their logical OR. The converter is flagged busy until the successive-approximation engine reports completion, or until a bounded conversion time runs out.

At the end of each conversion, the level of the start input decides what happens next. If the input is high, the block stays powered, and the input's next falling edge starts the next conversion at once (high-speed mode). If the input is low, the block drops power (auto power-down mode). After each conversion the sample circuit gets a minimum tracking interval before the next hold.

All intervals are counted in clock cycles. They are derived from the clock frequency in MHz and from times given in nanoseconds. With the defaults (200 MHz, 1500 ns power-up, 2300 ns conversion, 100 ns tracking) the counts are 300, 460 and 20 cycles. The start input passes through a two-flop synchronizer.

The controller has four states. SLEEP is powered down. PWRUP means the power-up interval is running. WAIT_EXT means the block is powered and waiting for the start input to be low once tracking is complete. CONVERT means the sample is held and the block is busy. The transitions are:
- SLEEP to PWRUP on a synchronized rising edge.
- PWRUP to CONVERT when the interval ends with the input low and tracking complete; otherwise PWRUP to WAIT_EXT.
- WAIT_EXT to CONVERT when the input is low and tracking is complete.
- WAIT_EXT to PWRUP on a fresh rising edge.
- CONVERT to WAIT_EXT on completion or timeout with the input high; CONVERT to SLEEP on completion or timeout with the input low.

Top module: `cvs_sequencer`

## Requirements
- R1: After reset, pwr_en, hold and busy are all 0 (powered down, tracking, idle).
- R2: In SLEEP, a start_ext pulse at least 4 clock cycles (20 ns) wide raises pwr_en on the 3rd rising clock edge after the input rises. With start_ext already low, busy then rises exactly PWRUP_CYC (300) cycles after pwr_en rises.
- R3: If start_ext is still high when the power-up interval ends, no conversion starts while it stays high. busy rises on the 3rd clock edge after start_ext falls, within the 30 ns bound.
- R4: busy and hold are high in exactly the same cycles. busy falls on the clock edge after the cycle in which conv_done is sampled high, so a conv_done pulse L cycles after busy rises gives a busy width of L cycles.
- R5: If conv_done never arrives, busy falls after exactly CONV_CYC (460) cycles.
- R6: If start_ext is high in the cycle busy falls, pwr_en stays 1 and no conversion starts while the input stays high. Its next falling edge starts a conversion on the 3rd edge, with no power-up interval.
- R7: If start_ext is low in the cycle busy falls, pwr_en falls on the same edge as busy. pwr_en never falls at any other time.
- R8: The next busy rise comes no sooner than TRACK_CYC (20) cycles after busy falls. A start_ext fall just after end of conversion is deferred to exactly that point.
- R9: A rising edge on start_ext while busy is high is ignored. It neither shortens nor restarts the conversion, and it launches no power-up interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_ext | input | 1 | Asynchronous external convert-start |
| conv_done | input | 1 | Completion pulse from the bit-trial engine |
| pwr_en | output | 1 | Analog power enable |
| hold | output | 1 | Track/hold in hold, start of bit trials |
| busy | output | 1 | Conversion in progress |

## Verification
The bench holds start_ext high well past the power-up interval. A design that triggers on the internal pulse alone would start converting early. It checks the power-up wait to the exact cycle, so a trigger taken from the wrong edge or a counter off by one shows up as a count other than 300. It also ends conversions with the start input both high and low. A swapped mode decision would leave the block asleep when it should stay awake, or the reverse. The bench drops the start input one cycle after busy falls, so a missing tracking guard would re-enter conversion after 3 cycles instead of 20. It pulses the start input mid-conversion, so a design that restarts power-up on that edge would cut busy short or fail to sleep.

// File: rtl/cvs_pkg.sv
`timescale 1ns/1ps
package cvs_pkg;
    typedef enum logic [1:0] {
        ST_SLEEP    = 2'd0,
        ST_PWRUP    = 2'd1,
        ST_WAIT_EXT = 2'd2,
        ST_CONVERT  = 2'd3
    } cvs_state_t;
endpackage

// File: rtl/cvs_sync.sv
`timescale 1ns/1ps
module cvs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise
);
    // pipe[STAGES-1] is the synchronized level, pipe[STAGES] its previous value
    logic [STAGES:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-1:0], async_in};
    end

    assign level = pipe[STAGES-1];
    assign rise  = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/cvs_timer.sv
`timescale 1ns/1ps
module cvs_timer #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic done
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    // counts cycles since clear dropped, saturating at LIMIT-1
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (clear)        cnt <= '0;
        else if (cnt != LAST)  cnt <= cnt + 1'b1;
    end

    assign done = (cnt == LAST);
endmodule

// File: rtl/cvs_sequencer.sv
`timescale 1ns/1ps
module cvs_sequencer
    import cvs_pkg::*;
#(
    parameter int CLK_MHZ     = 200,
    parameter int PWRUP_NS    = 1500,
    parameter int CONV_NS     = 2300,
    parameter int TRACK_NS    = 100,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_ext,
    input  logic conv_done,
    output logic pwr_en,
    output logic hold,
    output logic busy
);
    localparam int PWRUP_CYC = CLK_MHZ * PWRUP_NS / 1000;
    localparam int CONV_CYC  = CLK_MHZ * CONV_NS  / 1000;
    localparam int TRACK_CYC = CLK_MHZ * TRACK_NS / 1000;

    cvs_state_t state_q, state_d;
    logic ext_lvl, ext_rise;
    logic pwr_done, conv_tmo, guard_done;

    cvs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (start_ext),
        .level    (ext_lvl),
        .rise     (ext_rise)
    );

    // self-timed power-up interval, runs only in PWRUP
    cvs_timer #(.LIMIT(PWRUP_CYC)) u_pwrup (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_q != ST_PWRUP),
        .done  (pwr_done)
    );

    // upper bound on conversion length
    cvs_timer #(.LIMIT(CONV_CYC)) u_conv (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_q != ST_CONVERT),
        .done  (conv_tmo)
    );

    // minimum tracking interval after end of conversion
    cvs_timer #(.LIMIT(TRACK_CYC)) u_track (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_q == ST_CONVERT),
        .done  (guard_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SLEEP;
        else        state_q <= state_d;
    end

    // next state: hold comes at the later of pulse end and input fall
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SLEEP: begin
                if (ext_rise) state_d = ST_PWRUP;
            end
            ST_PWRUP: begin
                if (pwr_done)
                    state_d = (!ext_lvl && guard_done) ? ST_CONVERT : ST_WAIT_EXT;
            end
            ST_WAIT_EXT: begin
                if (!ext_lvl && guard_done) state_d = ST_CONVERT;
                else if (ext_rise)          state_d = ST_PWRUP;
            end
            ST_CONVERT: begin
                // rising edges here are ignored; input level picks the mode
                if (conv_done || conv_tmo)
                    state_d = ext_lvl ? ST_WAIT_EXT : ST_SLEEP;
            end
            default: state_d = ST_SLEEP;
        endcase
    end

    // registered outputs decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwr_en <= 1'b0;
            hold   <= 1'b0;
            busy   <= 1'b0;
        end else begin
            pwr_en <= (state_d != ST_SLEEP);
            hold   <= (state_d == ST_CONVERT);
            busy   <= (state_d == ST_CONVERT);
        end
    end
endmodule

// File: rtl/cvs_sequencer_chk.sv
`timescale 1ns/1ps
module cvs_sequencer_chk #(
    parameter int PWRUP_CYC = 300,
    parameter int CONV_CYC  = 460,
    parameter int TRACK_CYC = 20
) (
    input logic clk,
    input logic rst_n,
    input logic pwr_en,
    input logic busy
);
    localparam int W = $clog2(PWRUP_CYC + CONV_CYC + TRACK_CYC + 2);

    logic [W-1:0] on_cnt, gap_cnt, bw_cnt;
    logic         first_conv;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            on_cnt     <= '0;
            gap_cnt    <= W'(TRACK_CYC);
            bw_cnt     <= '0;
            first_conv <= 1'b1;
        end else begin
            if (!pwr_en)                       on_cnt <= '0;
            else if (on_cnt != W'(PWRUP_CYC))  on_cnt <= on_cnt + 1'b1;

            if (busy)                          gap_cnt <= '0;
            else if (gap_cnt != W'(TRACK_CYC)) gap_cnt <= gap_cnt + 1'b1;

            if (!busy)                         bw_cnt <= '0;
            else if (bw_cnt != W'(CONV_CYC+1)) bw_cnt <= bw_cnt + 1'b1;

            if (!pwr_en)                       first_conv <= 1'b1;
            else if (busy)                     first_conv <= 1'b0;
        end
    end

    // R2: first conversion after wake waits out the full power-up interval
    assert_wake_before_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && first_conv) |-> (on_cnt >= W'(PWRUP_CYC)));

    // R5: conversion length bounded
    assert_conv_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bw_cnt <= W'(CONV_CYC));

    // R8: tracking gap before every hold
    assert_track_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (gap_cnt >= W'(TRACK_CYC)));

    // R7: power drops only together with the end of a conversion
    assert_sleep_at_eoc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_en) |-> $fell(busy));

    // R7: never busy while unpowered
    assert_busy_powered_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> pwr_en);
endmodule

bind cvs_sequencer cvs_sequencer_chk #(
    .PWRUP_CYC (PWRUP_CYC),
    .CONV_CYC  (CONV_CYC),
    .TRACK_CYC (TRACK_CYC)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .pwr_en (pwr_en),
    .busy   (busy)
);

// File: tb/sim_cvs_sequencer.sv
`timescale 1ns/1ps
module sim_cvs_sequencer;
    localparam int PWRUP_CYC = 300;
    localparam int CONV_CYC  = 460;
    localparam int TRACK_CYC = 20;
    localparam int DONE_LAT  = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_ext = 1'b0;
    logic conv_done = 1'b0;
    logic done_en = 1'b1;
    logic pwr_en, hold, busy;
    int   checks = 0;
    int   errors = 0;
    int   lat = 0;
    bit   ended = 0;

    always #2.5 clk = ~clk;

    cvs_sequencer u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_ext (start_ext),
        .conv_done (conv_done),
        .pwr_en    (pwr_en),
        .hold      (hold),
        .busy      (busy)
    );

    // bit-trial engine model: done pulse DONE_LAT cycles into a conversion
    always @(negedge clk) begin
        if (busy) lat = lat + 1;
        else      lat = 0;
        conv_done = done_en && (lat == DONE_LAT);
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic pulse4();
        start_ext = 1'b1;
        repeat (4) tick();
        start_ext = 1'b0;
    endtask

    task automatic wait_busy_rise();
        for (int i = 0; i < 2000 && !busy; i++) tick();
    endtask

    task automatic wait_busy_fall();
        for (int i = 0; i < 2000 && busy; i++) tick();
    endtask

    task automatic t_reset();
        repeat (3) tick();
        chk("R1 pwr_en", pwr_en, 0);
        chk("R1 busy", busy, 0);
        chk("R1 hold", hold, 0);
    endtask

    task automatic t_wake_pulse();
        int n = 0;
        int w = 0;
        int bad = 0;
        start_ext = 1'b1;
        while (!pwr_en && n < 10) begin tick(); n++; end
        chk("R2 wake latency", n, 3);
        tick();
        start_ext = 1'b0;
        n = 2;
        forever begin
            tick();
            if (busy || n > 1000) break;
            n++;
        end
        chk("R2 power-up cycles", n, PWRUP_CYC);
        while (busy && w < 2000) begin
            if (hold !== busy) bad++;
            w++;
            tick();
        end
        chk("R4 busy width", w, DONE_LAT);
        chk("R4 hold follows busy", bad, 0);
        chk("R7 sleep at end", pwr_en, 0);
        chk("R4 hold released", hold, 0);
    endtask

    task automatic t_long_high();
        int early = 0;
        int n = 0;
        int bad = 0;
        start_ext = 1'b1;
        for (int i = 0; i < 10 && !pwr_en; i++) tick();
        for (int i = 0; i < 500; i++) begin
            tick();
            if (busy) early++;
        end
        chk("R3 no hold while input high", early, 0);
        chk("R3 still powered", pwr_en, 1);
        start_ext = 1'b0;
        while (!busy && n < 20) begin tick(); n++; end
        chk("R3 fall to busy", n, 3);
        repeat (50) tick();
        start_ext = 1'b1;
        wait_busy_fall();
        chk("R6 stays powered", pwr_en, 1);
        for (int i = 0; i < 50; i++) begin
            tick();
            if (busy || !pwr_en) bad++;
        end
        chk("R6 idle while input high", bad, 0);
        start_ext = 1'b0;
        n = 0;
        while (!busy && n < 400) begin tick(); n++; end
        chk("R6 direct restart", n, 3);
        wait_busy_fall();
        chk("R7 sleep after low end", pwr_en, 0);
    endtask

    task automatic t_guard();
        int g = 1;
        int hb = 0;
        start_ext = 1'b1;
        for (int i = 0; i < 10 && !pwr_en; i++) tick();
        repeat (350) tick();
        start_ext = 1'b0;
        wait_busy_rise();
        repeat (10) tick();
        start_ext = 1'b1;
        wait_busy_fall();
        start_ext = 1'b0;
        forever begin
            tick();
            if (busy || g > 200) break;
            g++;
            if (hold) hb++;
        end
        chk("R8 tracking gap", g, TRACK_CYC);
        chk("R8 hold low in gap", hb, 0);
        wait_busy_fall();
        chk("R7 sleep after guard case", pwr_en, 0);
    endtask

    task automatic t_timeout();
        int w = 0;
        done_en = 1'b0;
        pulse4();
        wait_busy_rise();
        while (busy && w < 2000) begin w++; tick(); end
        chk("R5 timeout width", w, CONV_CYC);
        done_en = 1'b1;
    endtask

    task automatic t_ignore();
        int w = 0;
        int act = 0;
        pulse4();
        wait_busy_rise();
        while (busy && w < 2000) begin
            w++;
            tick();
            if (w == 20) start_ext = 1'b1;
            if (w == 26) start_ext = 1'b0;
        end
        chk("R9 width unchanged", w, DONE_LAT);
        chk("R9 sleeps after", pwr_en, 0);
        for (int i = 0; i < 400; i++) begin
            tick();
            if (busy || pwr_en) act++;
        end
        chk("R9 no relaunch", act, 0);
    endtask

    initial begin
        repeat (4) tick();
        rst_n = 1'b1;
        t_reset();
        t_wake_pulse();
        repeat (50) tick();
        t_long_high();
        repeat (50) tick();
        t_guard();
        repeat (50) tick();
        t_timeout();
        repeat (50) tick();
        t_ignore();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", 1, 0);
            finish_run();
        end
    end
endmodule